// File: doc/BRIEF.md
# SPI Host Port with Shared Data Buffer

This block is a serial peripheral interface host that a small processor drives over a plain register bus. It is sized for memory-card command traffic. Software writes one byte to the data register. That byte goes straight into an internal shift register, which software cannot see. From there it leaves on `mosi` most significant bit first, while the byte arriving on `miso` is shifted in. When the eighth bit is done, the received byte lands in the data register, and a sticky completion flag (and the interrupt, if enabled) tells software to collect it.

Clock polarity, the phase of data against the clock, the capture point and a three-step clock divider come from a control register. At reset the port is set up for memory cards: the clock idles high and the data line idles high. Chip select is a plain software-owned output. Software lowers it before a command and raises it only after the command and all of its responses have been exchanged.

Top module: `spi_host_port`

Register map (`bus_addr`): 0 = DATA, 1 = CTRL, 2 = STAT, 3 = MISC. Reads are combinational on `bus_rdata`. Writes take effect on the clock edge where `bus_wr` is high.

## Requirements
- R1: After reset, CTRL reads 0x06, MISC reads 0x02, STAT reads 0x00 and DATA reads 0x00. `cs_n`, `sclk` and `mosi` are high and `irq` is low.
- R2: Writing DATA while CTRL bit0 (enable) is 1 and the port is idle sends the written byte on `mosi`, most significant bit first. Each bit is held for one full `sclk` period.
- R3: CTRL bits[5:4] select a half-period H of `sclk`: 2, 8, 32 or 32 clock cycles for the values 0 to 3 (`sclk` = clk/4, /16, /64). The completion flag and `irq` go high exactly 16·H+1 cycles after the clock edge that accepted the DATA write.
- R4: The byte sampled from `miso` is read back from DATA for every mode combination. CTRL bit1 (cpol) is the idle level of `sclk`. With CTRL bit2 (cke) = 1, `sclk` sits at the idle level in the first half of each bit and at the opposite level in the second half. With cke = 0 this is reversed. CTRL bit3 (smp) = 0 captures `miso` at the middle of each bit; smp = 1 captures it at the end of each bit.
- R5: Whenever no byte is moving, `mosi` is high and `sclk` equals cpol.
- R6: STAT bit0 (done) is 0 while waiting and is set when a byte completes. A STAT write with bit0 = 0 clears it; a write with bit0 = 1 leaves it set.
- R7: `irq` is high exactly while MISC bit0 (interrupt enable) and STAT bit0 are both 1.
- R8: A DATA write while STAT bit4 (busy) is 1 is ignored, and the byte on the wire is unaffected. The write sets the sticky STAT bit3 (collision), which only a STAT write with bit3 = 0 clears.
- R9: STAT bit1 (full) is set when a received byte lands in DATA. It is cleared by a bus read of DATA (`bus_rd` high with `bus_addr` = 0); a STAT write does not clear it.
- R10: If a byte completes while full is 1, the sticky STAT bit2 (overflow) is set and DATA keeps the earlier byte. A STAT write with bit2 = 0 clears overflow.
- R11: `cs_n` follows MISC bit1 and changes only on a MISC write, never because of a transfer.
- R12: With enable = 0, a DATA write starts nothing: `sclk` stays idle, busy and done stay 0.
- R13: The shift register is not visible on the bus. While a byte is in flight, DATA still reads the last received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; has a side effect only on DATA |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Chip select, active low, software driven |

## Verification
A model of the target device drives `miso` and captures `mosi` on the `sclk` edges, with the edge choice following the selected phase. Byte pairs are chosen so that reversed bit order, a stuck line or a lost first or last bit each give a different result: 0xA5/0x3C, 0x00/0xFF, 0xFF/0x00, 0x81/0x7E, 0x5A/0xC3 and others. These pairs are run across both polarities, both phases, both capture points and every divider value. A capture half a bit early or late, or a divider off by one, therefore shows up as a wrong byte or a wrong completion cycle count. Separate sequences cover the following:
- a DATA write in the middle of a transfer;
- two completions without a read in between;
- a disabled port;
- the interplay of the interrupt enable and the completion flag.

// File: rtl/spih_pkg.sv
`timescale 1ns/1ps
package spih_pkg;

    localparam int BYTE_W   = 8;
    localparam int HALF_MAX = 32;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_STAT = 2'd2,
        REG_MISC = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic [1:0] div;
        logic       smp;
        logic       cke;
        logic       cpol;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       busy;
        logic       col;
        logic       ovf;
        logic       full;
        logic       done;
    } stat_t;

    localparam ctrl_t CTRL_RST = '{rsvd: 2'b00, div: 2'b00, smp: 1'b0,
                                   cke: 1'b1, cpol: 1'b1, en: 1'b0};

    // half period of sclk, in system clocks, for a divider select value
    function automatic int unsigned half_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 8;
            default: return HALF_MAX;
        endcase
    endfunction

endpackage

// File: rtl/spih_clkgen.sv
`timescale 1ns/1ps
module spih_clkgen
    import spih_pkg::*;
#(
    parameter int CW = $clog2(HALF_MAX)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb last = CW'(half_len(sel) - 1);

    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/spih_shifter.sv
`timescale 1ns/1ps
module spih_shifter
    import spih_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] tx_in,
    input  logic          cpol,
    input  logic          cke,
    input  logic          smp,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_out
);

    localparam int HW = $clog2(2 * DW);
    localparam logic [HW-1:0] LAST_HALF = HW'(2 * DW - 1);

    logic [HW-1:0] half;
    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic          samp_now;
    logic          end_now;

    always_comb begin
        samp_now = smp ? half[0] : ~half[0];
        end_now  = busy && tick && (half == LAST_HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            half  <= '0;
            tx_sr <= '1;
            rx_sr <= '0;
            done  <= 1'b0;
        end else begin
            done <= end_now;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    half  <= '0;
                    tx_sr <= tx_in;
                end
            end else if (tick) begin
                if (samp_now) begin
                    rx_sr <= {rx_sr[DW-2:0], miso};
                end
                if (half[0] && !end_now) begin
                    tx_sr <= {tx_sr[DW-2:0], 1'b1};
                end
                if (end_now) begin
                    busy <= 1'b0;
                end else begin
                    half <= half + 1'b1;
                end
            end
        end
    end

    assign sclk   = busy ? (cpol ^ half[0] ^ ~cke) : cpol;
    assign mosi   = busy ? tx_sr[DW-1] : 1'b1;
    assign rx_out = rx_sr;

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(tx_sr));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/spih_regs.sv
`timescale 1ns/1ps
module spih_regs
    import spih_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          xfer_done,
    input  logic [DW-1:0] rx_byte,
    output logic          start,
    output logic [DW-1:0] tx_byte,
    output logic          cpol,
    output logic          cke,
    output logic          smp,
    output logic [1:0]    div,
    output logic          irq,
    output logic          cs_n
);

    ctrl_t         ctrl_q;
    stat_t         st;
    logic          done_q, full_q, ovf_q, col_q;
    logic          ie_q, cs_q;
    logic [DW-1:0] rbuf;
    reg_addr_e     a;
    logic          wr_data, wr_ctrl, wr_stat, wr_misc, rd_data;
    logic [7:0]    ctrl_bits;
    logic [7:0]    stat_bits;
    logic [7:0]    misc_bits;

    always_comb begin
        a       = reg_addr_e'(addr);
        wr_data = wr && (a == REG_DATA);
        wr_ctrl = wr && (a == REG_CTRL);
        wr_stat = wr && (a == REG_STAT);
        wr_misc = wr && (a == REG_MISC);
        rd_data = rd && (a == REG_DATA);
        start   = wr_data && ctrl_q.en && !busy;
        tx_byte = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            ie_q   <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            col_q  <= 1'b0;
            rbuf   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[7:0]);
            end
            if (wr_misc) begin
                ie_q <= wdata[0];
                cs_q <= wdata[1];
            end
            if (xfer_done) begin
                done_q <= 1'b1;
            end else if (wr_stat && !wdata[0]) begin
                done_q <= 1'b0;
            end
            if (wr_data && busy) begin
                col_q <= 1'b1;
            end else if (wr_stat && !wdata[3]) begin
                col_q <= 1'b0;
            end
            if (xfer_done && full_q) begin
                ovf_q <= 1'b1;
            end else if (wr_stat && !wdata[2]) begin
                ovf_q <= 1'b0;
            end
            if (xfer_done && !full_q) begin
                full_q <= 1'b1;
                rbuf   <= rx_byte;
            end else if (rd_data) begin
                full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        st        = '{rsvd: 3'b000, busy: busy, col: col_q, ovf: ovf_q,
                      full: full_q, done: done_q};
        ctrl_bits = ctrl_q;
        stat_bits = st;
        misc_bits = {6'b000000, cs_q, ie_q};
        case (a)
            REG_DATA: rdata = rbuf;
            REG_CTRL: rdata = DW'(ctrl_bits);
            REG_STAT: rdata = DW'(stat_bits);
            default:  rdata = DW'(misc_bits);
        endcase
    end

    assign cpol = ctrl_q.cpol;
    assign cke  = ctrl_q.cke;
    assign smp  = ctrl_q.smp;
    assign div  = ctrl_q.div;
    assign irq  = ie_q && done_q;
    assign cs_n = cs_q;

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(xfer_done));

    // R10
    ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $stable(rbuf));

    // R8
    col_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(col_q) |-> $past(wr && (addr == 2'd0) && busy));

    // R9
    full_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(rd && (addr == 2'd0)));

    // R11
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && (addr == 2'd3)) |=> $stable(cs_q));

endmodule

// File: rtl/spi_host_port.sv
`timescale 1ns/1ps
module spi_host_port
    import spih_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);

    logic          busy, xfer_done, start, tick;
    logic          cpol, cke, smp;
    logic [1:0]    div;
    logic [DW-1:0] rx_byte, tx_byte;

    spih_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_byte   (rx_byte),
        .start     (start),
        .tx_byte   (tx_byte),
        .cpol      (cpol),
        .cke       (cke),
        .smp       (smp),
        .div       (div),
        .irq       (irq),
        .cs_n      (cs_n)
    );

    spih_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .sel  (div),
        .tick (tick)
    );

    spih_shifter #(.DW(DW)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tx_in  (tx_byte),
        .cpol   (cpol),
        .cke    (cke),
        .smp    (smp),
        .tick   (tick),
        .miso   (miso),
        .busy   (busy),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (xfer_done),
        .rx_out (rx_byte)
    );

endmodule

// File: tb/sim_spi_host_port.sv
`timescale 1ns/1ps
module sim_spi_host_port;
    import spih_pkg::*;

    localparam int DW = 8;
    localparam int CLK_HALF_NS = 4;
    localparam int WATCHDOG_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq, sclk, mosi, cs_n;
    logic          miso = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    bit finished = 1'b0;

    always #CLK_HALF_NS clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_host_port #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues: driver pushes, monitors pop
    logic [DW-1:0] mosi_q[$];
    logic [DW-1:0] rx_q[$];
    bit            bench_full = 1'b0;
    logic [DW-1:0] landed = '0;

    // target device model
    bit            dev_on = 1'b0;
    bit            dev_cke = 1'b1;
    int            edges = 0;
    int            capn = 0;
    logic [DW-1:0] dev_sh = '0;
    logic [DW-1:0] dev_cap = '0;
    bit            cur_cpol = 1'b1;
    bit            cur_cke = 1'b1;

    always @(sclk) begin
        if (dev_on) begin
            edges++;
            if (dev_cke ? (edges % 2 == 1) : (edges % 2 == 0)) begin
                if (capn < DW) begin
                    dev_cap = {dev_cap[DW-2:0], mosi};
                    capn++;
                    if (capn == DW) begin
                        if (mosi_q.size() == 0) begin
                            check_eq("R2", "unexpected mosi byte", dev_cap, '1);
                        end else begin
                            check_eq("R2", "mosi byte", dev_cap, mosi_q.pop_front());
                        end
                    end
                end
            end else begin
                miso   = dev_sh[DW-1];
                dev_sh = {dev_sh[DW-2:0], 1'b1};
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic set_cfg(input bit cpol, input bit cke, input bit smp, input logic [1:0] div);
        cur_cpol = cpol;
        cur_cke  = cke;
        bus_write(REG_CTRL, {2'b00, div, smp, cke, cpol, 1'b1});
    endtask

    task automatic begin_xfer(input logic [DW-1:0] tx, input logic [DW-1:0] dev);
        edges   = 0;
        capn    = 0;
        dev_cke = cur_cke;
        if (cur_cke) begin
            miso   = dev[DW-1];
            dev_sh = {dev[DW-2:0], 1'b1};
        end else begin
            miso   = 1'b1;
            dev_sh = dev;
        end
        dev_on = 1'b1;
        mosi_q.push_back(tx);
        if (!bench_full) begin
            rx_q.push_back(dev);
            landed = dev;
        end
        bench_full = 1'b1;
        bus_write(REG_DATA, tx);
        t0 = cyc;
    endtask

    task automatic finish_xfer(input int half, input logic [DW-1:0] exp_stat,
                               input bit do_read, input bit keep_done, input string stat_req);
        logic [DW-1:0] v;
        while (irq !== 1'b1 && (cyc - t0) < 4000) @(negedge clk);
        check_eq("R3", "cycles to completion", cyc - t0, 16 * half + 1);
        dev_on = 1'b0;
        check_eq("R2", "bits seen by target", capn, DW);
        check_eq("R5", "mosi idle", mosi, 1'b1);
        check_eq("R5", "sclk idle", sclk, cur_cpol);
        check_eq("R11", "cs_n during transfer", cs_n, 1'b0);
        peek(REG_STAT, v);
        check_eq(stat_req, "status after completion", v, exp_stat);
        if (do_read) begin
            bus_read(REG_DATA, v);
            check_eq("R4", "received byte", v, rx_q.pop_front());
            bench_full = 1'b0;
        end
        if (!keep_done) begin
            bus_write(REG_STAT, 8'h00);
            peek(REG_STAT, v);
            check_eq("R9", "status after clear", v, bench_full ? 8'h02 : 8'h00);
            check_eq("R7", "irq after clear", irq, 1'b0);
        end
    endtask

    initial begin
        #(WATCHDOG_CYC * 2 * CLK_HALF_NS);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] prev;
        bit            sclk_moved;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(REG_CTRL, v); check_eq("R1", "CTRL reset", v, 8'h06);
        peek(REG_MISC, v); check_eq("R1", "MISC reset", v, 8'h02);
        peek(REG_STAT, v); check_eq("R1", "STAT reset", v, 8'h00);
        peek(REG_DATA, v); check_eq("R1", "DATA reset", v, 8'h00);
        check_eq("R1", "pins at reset", {cs_n, sclk, mosi, irq}, 4'b1110);

        // R12 disabled port ignores a DATA write
        bus_write(REG_DATA, 8'h55);
        sclk_moved = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk !== 1'b1) sclk_moved = 1'b1;
        end
        check_eq("R12", "sclk moved while disabled", sclk_moved, 1'b0);
        peek(REG_STAT, v); check_eq("R12", "STAT while disabled", v, 8'h00);

        // R11 select the target, enable interrupt
        bus_write(REG_MISC, 8'h01);
        check_eq("R11", "cs_n after MISC write", cs_n, 1'b0);

        // R4 mode sweep
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0);
        begin_xfer(8'hA5, 8'h3C); finish_xfer(2, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b1, 1'b0, 1'b0, 2'd0);
        begin_xfer(8'h00, 8'hFF); finish_xfer(2, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b1, 1'b1, 1'b1, 2'd0);
        begin_xfer(8'hFF, 8'h00); finish_xfer(2, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b0, 1'b1, 1'b1, 2'd1);
        begin_xfer(8'h81, 8'h7E); finish_xfer(8, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b0, 1'b0, 1'b0, 2'd2);
        begin_xfer(8'h5A, 8'hC3); finish_xfer(32, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b1, 1'b0, 1'b1, 2'd3);
        begin_xfer(8'h96, 8'h69); finish_xfer(32, 8'h03, 1'b1, 1'b0, "R6");
        set_cfg(1'b0, 1'b0, 1'b1, 2'd0);
        begin_xfer(8'h12, 8'hED); finish_xfer(2, 8'h03, 1'b1, 1'b0, "R6");

        // R8 collision and R13 hidden shift register
        set_cfg(1'b1, 1'b1, 1'b0, 2'd1);
        prev = landed;
        begin_xfer(8'hC6, 8'h39);
        repeat (20) @(negedge clk);
        peek(REG_DATA, v); check_eq("R13", "DATA during transfer", v, prev);
        peek(REG_STAT, v); check_eq("R8", "STAT busy before collision", v, 8'h10);
        bus_write(REG_DATA, 8'h00);
        peek(REG_STAT, v); check_eq("R8", "STAT after collision", v, 8'h18);
        finish_xfer(8, 8'h0B, 1'b1, 1'b0, "R8");
        peek(REG_STAT, v); check_eq("R8", "collision cleared", v & 8'h08, 8'h00);

        // R10 overflow keeps the first byte
        set_cfg(1'b0, 1'b1, 1'b0, 2'd0);
        begin_xfer(8'h11, 8'h22); finish_xfer(2, 8'h03, 1'b0, 1'b0, "R9");
        begin_xfer(8'h33, 8'h44); finish_xfer(2, 8'h07, 1'b1, 1'b0, "R10");

        // R6 and R7 flag and interrupt gating
        set_cfg(1'b1, 1'b1, 1'b0, 2'd0);
        begin_xfer(8'h4B, 8'hB4); finish_xfer(2, 8'h03, 1'b1, 1'b1, "R6");
        bus_write(REG_STAT, 8'h01);
        peek(REG_STAT, v); check_eq("R6", "done after writing 1", v, 8'h01);
        check_eq("R7", "irq with enable", irq, 1'b1);
        bus_write(REG_MISC, 8'h00);
        check_eq("R7", "irq with enable off", irq, 1'b0);
        bus_write(REG_MISC, 8'h01);
        check_eq("R7", "irq re-enabled", irq, 1'b1);
        bus_write(REG_STAT, 8'h00);
        peek(REG_STAT, v); check_eq("R6", "done after writing 0", v, 8'h00);
        check_eq("R7", "irq after done clear", irq, 1'b0);

        // R11 deselect
        bus_write(REG_MISC, 8'h03);
        check_eq("R11", "cs_n after deselect", cs_n, 1'b1);
        check_eq("R2", "mosi queue drained", mosi_q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule